// File: doc/BRIEF.md
# Key-Sequence Watchdog Timer

This block is a free-running watchdog for a processor subsystem. An 8-bit counter climbs by one on every oscillator clock while the watchdog is enabled. If the counter is allowed to reach its top value, it wraps to zero and the block raises a reset request that stays high for exactly 512 clock cycles. The rest of the chip uses that request to restart the subsystem.

Healthy software keeps the reset away in one of two ways. It can turn the counter off through a control register. It can also service the watchdog with an ordered pair of writes to a key register: first the arming value 0x55, then the firing value 0xAA. A firing value that arrives without a prior arm does nothing, so a runaway program that writes one fixed value cannot keep the watchdog quiet by accident.

Both registers sit on a small write-only register bus. The present count is driven on an output port, so the state of the counter can be seen from outside the block.

Top module: `wdk_watchdog`

## Requirements
- R1: After reset the count is 0, the reset request is low and the counter is enabled, so it starts counting on the first clock edge without any register write.
- R2: While enabled, with no clear taking effect, the count rises by exactly one on each clock edge.
- R3: On the edge where an enabled counter at 255 would advance, the count wraps to 0 and the reset request rises. The request then stays high for exactly 512 consecutive cycles.
- R4: An overflow that occurs while the request is high neither restarts nor lengthens it. A free-running counter therefore gives a request that is high for 512 cycles, low for 256 cycles, and then high again.
- R5: A write of 0xAA to the key register (address 0) while the sequence is armed sets the count to 0 on that edge. This clear takes priority over counting. A clear at count 255 therefore starts no reset request.
- R6: A write of 0xAA to the key register when the sequence is not armed leaves the count unchanged.
- R7: A key write of any value other than 0x55 or 0xAA leaves the armed state unchanged. A sequence of 0x55, then another value, then 0xAA still clears the count.
- R8: A write of 0x55 arms the sequence, and a repeated 0x55 keeps it armed. A clear disarms the sequence, so a second 0xAA with no new 0x55 does not clear the count.
- R9: Bit 0 of a write to the control register (address 1) sets the enable: 1 enables, 0 disables. The new value applies from the next edge. While disabled, the count holds and no reset request starts. Only control-register writes change the enable.
- R10: Writes to addresses other than 0 and 1 have no effect on the enable, on the armed state or on the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, sampled on the rising edge |
| wr_addr | input | 2 | Register address: 0 = key, 1 = control |
| wr_data | input | 8 | Write data |
| wd_count | output | 8 | Present counter value |
| wd_reset | output | 1 | Reset request, high for 512 cycles after an overflow |

## Verification
The key logic is driven with a set of short write sequences, each applied to a frozen counter: a correct arm-fire pair, a lone fire, a fire placed before the arm, an unrelated value between arm and fire, a doubled arm, and an arm followed only by unrelated values. Because the counter is frozen, a held count and a zeroed count can be told apart exactly. Separate runs let the counter overflow freely, which measures the pulse length and shows that the overflow inside the pulse is ignored. Further runs place a clear, and then a disable, exactly on the edge where the count sits at 255, which shows the priority of each over the wrap. Writes to unmapped addresses and key writes with bit 0 set are applied while the counter is disabled, to show that neither one reaches the enable or the arming logic.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

  typedef enum logic [1:0] {
    KEY_IGNORE = 2'd0,
    KEY_ARM    = 2'd1,
    KEY_FIRE   = 2'd2
  } key_kind_e;

  // Sort a key-register write into arm, fire or ignore.
  function automatic key_kind_e classify_key(
    input logic [7:0] data,
    input logic [7:0] arm_val,
    input logic [7:0] fire_val
  );
    if (data == arm_val)       return KEY_ARM;
    else if (data == fire_val) return KEY_FIRE;
    else                       return KEY_IGNORE;
  endfunction

  // True when an address selects a given register.
  function automatic logic addr_hit(
    input logic [1:0] addr,
    input logic [1:0] reg_addr
  );
    return addr == reg_addr;
  endfunction

endpackage

// File: rtl/wdk_regs.sv
module wdk_regs #(
  parameter int ADDR_W    = 2,
  parameter int DATA_W    = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = '0,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              key_wr,
  output logic [DATA_W-1:0] key_data,
  output logic              cnt_en
);

  logic ctrl_wr;

  assign key_wr   = wr_en && (wr_addr == KEY_ADDR);
  assign ctrl_wr  = wr_en && (wr_addr == CTRL_ADDR);
  assign key_data = wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_en <= 1'b1;
    else if (ctrl_wr) cnt_en <= wr_data[0];
  end

  // R9
  only_ctrl_changes_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == CTRL_ADDR) |=> $stable(cnt_en));

  // R10
  unmapped_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != CTRL_ADDR && wr_addr != KEY_ADDR) |=> ($stable(cnt_en) && !$past(key_wr)));

endmodule

// File: rtl/wdk_keyseq.sv
module wdk_keyseq
  import wdk_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] ARM_VAL  = 8'h55,
  parameter logic [DATA_W-1:0] FIRE_VAL = 8'hAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_data,
  output logic              armed,
  output logic              key_clr
);

  key_kind_e kind;

  assign kind    = key_wr ? classify_key(key_data, ARM_VAL, FIRE_VAL) : KEY_IGNORE;
  assign key_clr = (kind == KEY_FIRE) && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
    end else begin
      unique case (kind)
        KEY_ARM:  armed <= 1'b1;
        KEY_FIRE: armed <= 1'b0;
        default:  armed <= armed;
      endcase
    end
  end

  // R8
  disarm_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_clr |=> !armed);

  // R8
  arm_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && key_data == ARM_VAL) |=> armed);

  // R7
  other_value_keeps_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && key_data != ARM_VAL && key_data != FIRE_VAL) |=> (armed == $past(armed)));

  // R6
  lone_fire_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed) |-> !key_clr);

endmodule

// File: rtl/wdk_counter.sv
module wdk_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  assign ovf = cnt_en && !clr && (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (cnt_en) cnt <= cnt + CNT_W'(1);
  end

  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !clr) |=> (cnt == CNT_W'($past(cnt) + CNT_W'(1))));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !clr) |=> $stable(cnt));

  // R5
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

endmodule

// File: rtl/wdk_pulse.sv
module wdk_pulse #(
  parameter int PULSE_LEN = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic pulse_o
);

  localparam int PW = $clog2(PULSE_LEN + 1);

  logic [PW-1:0] left;
  logic          busy;

  assign busy    = (left != '0);
  assign pulse_o = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left <= '0;
    else if (busy)           left <= left - PW'(1);
    else if (start)          left <= PW'(PULSE_LEN);
  end

  // R3
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (left == PW'(PULSE_LEN)));

  // R4
  no_extend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> (left == PW'($past(left) - PW'(1))));

  // R9
  quiet_without_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !pulse_o);

endmodule

// File: rtl/wdk_watchdog.sv
module wdk_watchdog #(
  parameter int CNT_W     = 8,
  parameter int PULSE_LEN = 512,
  parameter int ADDR_W    = 2,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  wd_count,
  output logic              wd_reset
);

  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic              key_wr;
  logic [DATA_W-1:0] key_data;
  logic              cnt_en;
  logic              armed;
  logic              key_clr;
  logic              ovf;

  wdk_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .KEY_ADDR(ADDR_W'(0)), .CTRL_ADDR(ADDR_W'(1))
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .key_wr(key_wr), .key_data(key_data), .cnt_en(cnt_en)
  );

  wdk_keyseq #(
    .DATA_W(DATA_W), .ARM_VAL(DATA_W'(8'h55)), .FIRE_VAL(DATA_W'(8'hAA))
  ) u_keys (
    .clk(clk), .rst_n(rst_n),
    .key_wr(key_wr), .key_data(key_data),
    .armed(armed), .key_clr(key_clr)
  );

  wdk_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .cnt_en(cnt_en), .clr(key_clr),
    .cnt(wd_count), .ovf(ovf)
  );

  wdk_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n),
    .start(ovf), .pulse_o(wd_reset)
  );

  // R5
  clear_beats_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_clr && wd_count == TOP && !wd_reset) |=> (wd_count == '0 && !wd_reset));

  // R3
  wrap_raises_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !key_clr && wd_count == TOP && !wd_reset) |=> (wd_count == '0 && wd_reset));

  // R9
  disabled_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !wd_reset) |=> !wd_reset);

endmodule

// File: tb/wdk_watchdog_test.sv
`timescale 1ns/1ps
module wdk_watchdog_test;

  localparam logic [1:0] A_KEY  = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;

  typedef struct packed {
    logic       clr;
    logic [1:0] n;
    logic [7:0] d0;
    logic [7:0] d1;
    logic [7:0] d2;
  } kvec_t;

  // Key sequences applied to a frozen counter; clr = expect count zeroed.
  localparam kvec_t VEC [7] = '{
    '{1'b1, 2'd2, 8'h55, 8'hAA, 8'h00},  // R5 plain pair
    '{1'b0, 2'd1, 8'hAA, 8'h00, 8'h00},  // R6 lone fire
    '{1'b1, 2'd3, 8'h55, 8'h12, 8'hAA},  // R7 other value between
    '{1'b1, 2'd3, 8'h55, 8'h55, 8'hAA},  // R8 doubled arm
    '{1'b0, 2'd2, 8'hAA, 8'h55, 8'h00},  // R6 fire before arm
    '{1'b0, 2'd2, 8'h12, 8'hAA, 8'h00},  // R6 other then fire
    '{1'b0, 2'd3, 8'h55, 8'h00, 8'hFF}   // R7 arm, no fire
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] wd_count;
  logic       wd_reset;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdk_watchdog uut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wd_count(wd_count), .wd_reset(wd_reset)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0;
    tick(2);
    rst_n = 1'b1;
  endtask

  task automatic wait_count(input int v);
    while (wd_count != 8'(v)) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int held;
    int highs;
    logic [7:0] d;

    // Key-sequence table
    for (int i = 0; i < 7; i++) begin
      do_reset();
      tick(20);
      wr(A_CTRL, 8'h00);
      held = wd_count;
      for (int j = 0; j < int'(VEC[i].n); j++) begin
        d = (j == 0) ? VEC[i].d0 : (j == 1) ? VEC[i].d1 : VEC[i].d2;
        wr(A_KEY, d);
      end
      check("R5 R6 R7 R8 key vector", wd_count, VEC[i].clr ? 0 : held);
    end

    // R1 reset state
    do_reset();
    check("R1 count after reset", wd_count, 0);
    check("R1 request after reset", wd_reset, 0);
    // R2 counting, R3/R4 overflow and pulse shape
    highs = 0;
    for (int n = 1; n <= 1030; n++) begin
      @(negedge clk);
      if (n <= 1023 && wd_reset) highs++;
      if (n == 5)    check("R1 R2 enabled count", wd_count, 5);
      if (n == 100)  check("R2 count", wd_count, 100);
      if (n == 255)  check("R3 before wrap", wd_reset, 0);
      if (n == 256)  check("R3 wrap to zero", wd_count, 0);
      if (n == 256)  check("R3 request rises", wd_reset, 1);
      if (n == 767)  check("R3 last high", wd_reset, 1);
      if (n == 768)  check("R4 not extended", wd_reset, 0);
      if (n == 1023) check("R4 low gap", wd_reset, 0);
      if (n == 1024) check("R4 next pulse", wd_reset, 1);
    end
    check("R3 pulse width", highs, 512);

    // R5 clear on the wrap edge wins
    do_reset();
    wait_count(250);
    wr(A_KEY, 8'h55);
    wait_count(255);
    wr(A_KEY, 8'hAA);
    check("R5 clear at top", wd_count, 0);
    check("R5 no request", wd_reset, 0);
    tick(10);
    check("R5 counting resumes", wd_count, 10);
    check("R5 still no request", wd_reset, 0);

    // R8 disarm after clear
    do_reset();
    tick(5);
    wr(A_CTRL, 8'h00);
    wr(A_KEY, 8'h55);
    wr(A_KEY, 8'hAA);
    check("R8 first clear", wd_count, 0);
    wr(A_CTRL, 8'h01);
    tick(7);
    wr(A_CTRL, 8'h00);
    held = wd_count;
    wr(A_KEY, 8'hAA);
    check("R8 second fire ignored", wd_count, held);

    // R9 disable at top, R10 unmapped writes
    do_reset();
    wait_count(254);
    wr(A_CTRL, 8'h00);
    check("R9 last step", wd_count, 255);
    highs = 0;
    for (int n = 0; n < 300; n++) begin
      @(negedge clk);
      if (wd_reset) highs++;
    end
    check("R9 held at top", wd_count, 255);
    check("R9 no request while disabled", highs, 0);
    wr(A_KEY, 8'h01);
    wr(2'd2, 8'h01);
    wr(2'd3, 8'h01);
    tick(5);
    check("R9 R10 enable untouched", wd_count, 255);
    wr(2'd3, 8'h55);
    wr(A_KEY, 8'hAA);
    check("R10 unmapped arm ignored", wd_count, 255);
    wr(A_CTRL, 8'h01);
    check("R9 enable applies next edge", wd_count, 255);
    @(negedge clk);
    check("R9 R3 wrap after enable", wd_count, 0);
    check("R9 R3 request after enable", wd_reset, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule